// File: doc/BRIEF.md
# Four-Switch PWM Sequencer with Deadband

This block turns a duty-cycle command into gate commands for a power stage with four switches. Two switches sit on the primary side and two act as synchronous rectifiers on the secondary side. A free-running counter sets the PWM period. The counter restarts early when an external sync pulse arrives, so several sequencers can lock to the fastest source among them. The requested duty is clamped to a window that is symmetric around half the period, and the block raises an overrange flag whenever the clamp acts.

The two primary switches are complementary. After every change of the raw PWM level, both are held off for a programmable number of cycles (the deadband). The secondary pair uses the same break-before-make rule, but its raw waveform is the primary one delayed by a programmable number of cycles. The result is that every secondary transition follows the matching primary transition by that delay.

The two pairs are gated separately. When the enable is high, all four switches run. When the enable is low and the amplitude code is nonzero, only the secondary pair runs. When the enable is low and the amplitude code is zero, all four switches are held off. The block also drives two further outputs: a 50% boost-drive clock at the PWM rate, and a one-cycle low-going sync pulse at the start of each period.

Top module: `pwm_sequencer`

## Requirements
- R1: While reset is asserted, all four switch outputs are 0, the counter is at zero (`sync_no` = 0), and `boost_o` is 1.
- R2: The counter runs 0 … `period_i`−1 and wraps. `sync_no` is 0 for exactly the one cycle in which the counter is zero.
- R3: A low level on `ext_sync_ni` at a clock edge loads the counter with zero, so `sync_no` is 0 in the following cycle.
- R4: The effective duty is `duty_i` clamped into [`dmin_i`, `period_i`−`dmin_i`]. `ovr_o` is 1 exactly when `duty_i` lies outside that window.
- R5: The raw primary level is 1 while the counter is below the effective duty. After each change of that level, `sw1_o` and `sw2_o` are both 0 for `db_i` cycles. After that gap, `sw1_o` follows a raw level of 1 and `sw2_o` follows a raw level of 0.
- R6: `sw3_o` and `sw4_o` obey the same rule as `sw1_o` and `sw2_o`, but the raw level is evaluated at counter value (count − `dly_i`) mod `period_i`. Their transitions therefore lag the primary transitions by `dly_i` cycles.
- R7: If `enable_i` was 1 at the previous clock edge, all four switches carry their sequenced values.
- R8: If `enable_i` was 0 and `amp_i` was nonzero at the previous edge, `sw1_o` and `sw2_o` are 0 while `sw3_o` and `sw4_o` keep switching.
- R9: If `enable_i` was 0 and `amp_i` was 2'b00 at the previous edge, all four switches are 0.
- R10: `boost_o` is 1 while the counter is below `period_i`/2 (rounded down) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | PWM period in cycles |
| duty_i | input | CNT_W | Requested on-time in cycles |
| dmin_i | input | CNT_W | Minimum on-time; maximum is period minus this |
| db_i | input | DB_W | Deadband in cycles |
| dly_i | input | DB_W | Secondary lag in cycles |
| enable_i | input | 1 | Output enable |
| amp_i | input | 2 | Amplitude code; zero selects full shutdown when disabled |
| ext_sync_ni | input | 1 | External sync, active low; restarts the period |
| sw1_o | output | 1 | Primary high-side gate |
| sw2_o | output | 1 | Primary low-side gate |
| sw3_o | output | 1 | Secondary gate following sw1 |
| sw4_o | output | 1 | Secondary gate following sw2 |
| ovr_o | output | 1 | Duty clamp active |
| boost_o | output | 1 | 50% boost-drive clock |
| sync_no | output | 1 | Period-start pulse, active low |

## Verification
The assertions assume the following about the inputs: `period_i` changes only while reset is held, and is at least 4; `dmin_i` is at most half the period; and `dly_i` is below the period. Under those conditions the counter bound and the clamp window are well defined. The stimulus picks the period and the timing fields only while reset is held, and draws them from those ranges. Duty, enable, amplitude code and external sync pulses are randomized freely during a run. Duty values are drawn both inside and outside the clamp window so that the overrange path is exercised.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef enum logic [1:0] {GATE_OFF = 2'd0, GATE_SEC = 2'd1, GATE_ALL = 2'd2} gate_e;

  function automatic gate_e gate_of(input logic en, input logic [1:0] amp);
    if (en) return GATE_ALL;
    if (amp != 2'b00) return GATE_SEC;
    return GATE_OFF;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             ext_sync_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sync_no,
  output logic             boost_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= period_i - CNT_W'(1)) || !ext_sync_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign sync_no = (cnt_q != '0);
  assign boost_o = (cnt_q < (period_i >> 1));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_i);
  // R3
  ext_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sync_ni |=> cnt_q == '0);
endmodule

// File: rtl/duty_clamp.sv
module duty_clamp #(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dmin_i,
  output logic [CNT_W-1:0] duty_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] dmax;
  logic             below, above;

  assign dmax  = period_i - dmin_i;
  assign below = duty_i < dmin_i;
  assign above = duty_i > dmax;

  always_comb begin
    duty_o = duty_i;
    if (below)      duty_o = dmin_i;
    else if (above) duty_o = dmax;
  end

  assign ovr_o = below | above;
endmodule

// File: rtl/dead_gap.sv
module dead_gap #(
  parameter int DB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic [DB_W-1:0] gap_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            side_q;
  logic [DB_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_q <= 1'b0;
      gap_q  <= '0;
    end else if (raw_i != side_q) begin
      side_q <= raw_i;
      gap_q  <= gap_i;
    end else if (gap_q != '0) begin
      gap_q  <= gap_q - DB_W'(1);
    end
  end

  assign hi_o = side_q  && (gap_q == '0);
  assign lo_o = !side_q && (gap_q == '0);

  // R5
  gap_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i != side_q && gap_i != '0) |=> (!hi_o && !lo_o));
endmodule

// File: rtl/pwm_sequencer.sv
module pwm_sequencer
  import pwm_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DB_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dmin_i,
  input  logic [DB_W-1:0]  db_i,
  input  logic [DB_W-1:0]  dly_i,
  input  logic             enable_i,
  input  logic [1:0]       amp_i,
  input  logic             ext_sync_ni,
  output logic             sw1_o,
  output logic             sw2_o,
  output logic             sw3_o,
  output logic             sw4_o,
  output logic             ovr_o,
  output logic             boost_o,
  output logic             sync_no
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt, duty_eff;
  logic [EXT_W-1:0] sec_cnt, dly_ext;
  logic [1:0]       raw, hi, lo;
  gate_e            gate_q;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .period_i, .ext_sync_ni,
    .cnt_o(cnt), .sync_no, .boost_o
  );

  duty_clamp #(.CNT_W(CNT_W)) u_clamp (
    .period_i, .duty_i, .dmin_i, .duty_o(duty_eff), .ovr_o
  );

  // secondary sees the count shifted back by dly, modulo period
  assign dly_ext = EXT_W'(dly_i);
  assign sec_cnt = (EXT_W'(cnt) >= dly_ext) ? EXT_W'(cnt) - dly_ext
                                            : EXT_W'(cnt) + EXT_W'(period_i) - dly_ext;
  assign raw[0]  = cnt < duty_eff;
  assign raw[1]  = sec_cnt < EXT_W'(duty_eff);

  for (genvar g = 0; g < 2; g++) begin : g_pair
    dead_gap #(.DB_W(DB_W)) u_gap (
      .clk_i, .rst_ni, .raw_i(raw[g]), .gap_i(db_i), .hi_o(hi[g]), .lo_o(lo[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= GATE_OFF;
    else         gate_q <= gate_of(enable_i, amp_i);
  end

  assign sw1_o = hi[0] && (gate_q == GATE_ALL);
  assign sw2_o = lo[0] && (gate_q == GATE_ALL);
  assign sw3_o = hi[1] && (gate_q != GATE_OFF);
  assign sw4_o = lo[1] && (gate_q != GATE_OFF);

  // R9
  full_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && amp_i == 2'b00) |=> !(sw1_o || sw2_o || sw3_o || sw4_o));
  // R8
  pri_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !(sw1_o || sw2_o));
  // R5
  pri_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw1_o && sw2_o));
  // R4
  clamp_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmin_i <= (period_i >> 1)) |-> (duty_eff >= dmin_i && duty_eff <= period_i - dmin_i));
endmodule

// File: tb/sim_pwm_sequencer.sv
`timescale 1ns/1ps
module sim_pwm_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] period, duty, dmin;
  logic [5:0] db, dly;
  logic enable, ext_n;
  logic [1:0] amp;
  logic sw1, sw2, sw3, sw4, ovr, boost, sync_n;
  int checks = 0, fails = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  pwm_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .duty_i(duty), .dmin_i(dmin),
    .db_i(db), .dly_i(dly), .enable_i(enable), .amp_i(amp), .ext_sync_ni(ext_n),
    .sw1_o(sw1), .sw2_o(sw2), .sw3_o(sw3), .sw4_o(sw4), .ovr_o(ovr),
    .boost_o(boost), .sync_no(sync_n)
  );

  // reference state
  int m_cnt, m_gp, m_gs, m_gate;
  bit m_sp, m_ss;

  function automatic int eff_duty();
    int hi = int'(period) - int'(dmin);
    if (int'(duty) < int'(dmin)) return int'(dmin);
    if (int'(duty) > hi) return hi;
    return int'(duty);
  endfunction
  function automatic bit raw_pri();
    return m_cnt < eff_duty();
  endfunction
  function automatic bit raw_sec();
    int s = m_cnt - int'(dly);
    if (s < 0) s += int'(period);
    return s < eff_duty();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_sp <= 0; m_ss <= 0; m_gp <= 0; m_gs <= 0; m_gate <= 0;
    end else begin
      bit rp, rs;
      rp = raw_pri(); rs = raw_sec();
      m_cnt <= (!ext_n || m_cnt >= int'(period) - 1) ? 0 : m_cnt + 1;
      if (rp != m_sp) begin m_sp <= rp; m_gp <= int'(db); end
      else if (m_gp != 0) m_gp <= m_gp - 1;
      if (rs != m_ss) begin m_ss <= rs; m_gs <= int'(db); end
      else if (m_gs != 0) m_gs <= m_gs - 1;
      m_gate <= enable ? 2 : (amp != 0 ? 1 : 0);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R2 sync", sync_n, m_cnt != 0);
      chk("R10 boost", boost, m_cnt < int'(period) / 2);
      chk("R4 ovr", ovr, (int'(duty) < int'(dmin)) || (int'(duty) > int'(period) - int'(dmin)));
      chk("R5 sw1", sw1, m_gate == 2 && m_gp == 0 && m_sp);
      chk("R5 sw2", sw2, m_gate == 2 && m_gp == 0 && !m_sp);
      chk("R6 sw3", sw3, m_gate != 0 && m_gs == 0 && m_ss);
      chk("R6 sw4", sw4, m_gate != 0 && m_gs == 0 && !m_ss);
    end
  end

  task automatic start(input int per);
    @(negedge clk);
    rst_n = 1'b0;
    period = 10'(per);
    dmin = 10'($urandom_range(0, per / 2));
    db = 6'($urandom_range(0, 5));
    dly = 6'($urandom_range(0, (per - 1 < 20) ? per - 1 : 20));
    duty = 10'($urandom_range(0, per));
    enable = 1'b1; amp = 2'b11; ext_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 sw1", sw1, 1'b0); chk("R1 sw2", sw2, 1'b0);
    chk("R1 sw3", sw3, 1'b0); chk("R1 sw4", sw4, 1'b0);
    chk("R1 sync", sync_n, 1'b0); chk("R1 boost", boost, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_n = ($urandom_range(0, 99) < 2) ? 1'b0 : 1'b1;
      if ($urandom_range(0, 29) == 0) duty = 10'($urandom_range(0, int'(period)));
      if ($urandom_range(0, 59) == 0) enable = ~enable;
      if ($urandom_range(0, 59) == 0) amp = 2'($urandom_range(0, 3));
    end
    @(negedge clk); ext_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    period = 10'd16; duty = 10'd8; dmin = 10'd2; db = 6'd1; dly = 6'd2;
    enable = 1'b0; amp = 2'b00; ext_n = 1'b1;
    live = 1'b1;

    // directed corners
    start(20);
    duty = 10'd10; dmin = 10'd3; db = 6'd2; dly = 6'd3;
    enable = 1'b0; amp = 2'b00;
    repeat (45) @(negedge clk);
    // R9
    chk("R9 all off", sw1 | sw2 | sw3 | sw4, 1'b0);
    amp = 2'b10;
    begin
      int s3 = 0, s1 = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); s3 += sw3; s1 += sw1 | sw2;
      end
      // R8
      chk("R8 sec running", s3 > 0, 1'b1);
      chk("R8 pri held", s1 > 0, 1'b0);
    end
    enable = 1'b1;
    begin
      int s1 = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); s1 += sw1; end
      // R7
      chk("R7 pri running", s1 > 0, 1'b1);
    end
    repeat (5) @(negedge clk);
    ext_n = 1'b0; @(negedge clk); ext_n = 1'b1;
    // R3
    chk("R3 restart", sync_n, 1'b0);
    duty = 10'd1; @(negedge clk);
    chk("R4 low clamp", ovr, 1'b1);
    duty = 10'd18; @(negedge clk);
    chk("R4 high clamp", ovr, 1'b1);
    duty = 10'd17; @(negedge clk);
    chk("R4 edge inside", ovr, 1'b0);
    run_rand(60);

    for (int k = 0; k < 14; k++) begin
      start($urandom_range(4, 60));
      run_rand(500);
    end
    live = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule